// File: doc/BRIEF.md
# Interrupt Steering and Idle-Wake Controller

This block gathers up to 32 interrupt request lines from peripherals and presents them to a processor core on two request outputs: a normal request and a fast request. A per-source steering bit picks which output a source drives. A per-source enable bit decides whether the source is delivered at all. Some source positions are not populated. Those positions are held at zero wherever they appear.

A separate wake output tells a core in idle mode that it should resume. A single control bit sets how wake-up is qualified. With the bit clear, any populated source that is asserted wakes the core, whatever the enable bits hold. With the bit set, only asserted sources whose enable bit is also set wake the core. The wake output is pure combinational logic from the source lines and the stored settings, so a core with stopped clocks can still be woken.

Software reaches the settings through a single-cycle register port. Each request carries valid, write, a byte address and write data. Read data comes back one clock after the request.

Top module: `intc_steer_top`

## Requirements
- R1: After synchronous reset, the enable register, the steering register and the control bit all read 0. The normal and fast request outputs are 0 regardless of the source lines.
- R2: A read at offset 0x00 returns the current source lines ANDed with the populated-source set. Populated positions are bits 8 to 14 and 17 to 31; the other positions read 0.
- R3: The enable register at offset 0x04 is read/write, with 1 meaning delivered. Only populated positions store data; the others ignore writes and read 0.
- R4: The steering register at offset 0x08 is read/write, with 0 selecting the normal output and 1 selecting the fast output. Only populated positions store data; the others ignore writes and read 0.
- R5: The control register at offset 0x14 stores bit 0 (the wake-qualify bit). Bits 31:1 ignore writes and read 0.
- R6: The normal request output is the OR over populated sources that are asserted, enabled and steered with a 0. It is registered, so it follows a source change on the next rising clock edge.
- R7: The fast request output is the OR over populated sources that are asserted, enabled and steered with a 1. It has the same one-edge latency as R6.
- R8: When the wake-qualify bit is 0, the wake output is high whenever any populated source is asserted, whatever the enable register holds.
- R9: When the wake-qualify bit is 1, the wake output is high only when an asserted populated source is also enabled.
- R10: An asserted line at an unpopulated position never raises the normal request, the fast request or the wake output.
- R11: A read request is answered with rd_valid and data on the clock after the request, and with nothing otherwise. Offsets 0x0C and 0x10, and any other offset outside the map, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lines | input | 32 | Interrupt source levels, one per position |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset within the register window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Registered read data |
| irq_out | output | 1 | Normal interrupt request to the core |
| fiq_out | output | 1 | Fast interrupt request to the core |
| wake_out | output | 1 | Idle wake-up request (combinational) |

## Verification
A wrong steering or enable bit shows up one edge after the offending source is asserted: the request appears on the wrong output, or on neither. The bench therefore asserts single sources one at a time, after the settings have been written, and checks both outputs. A wrong wake-qualify bit does not change the request outputs. It shows only on the wake output, and only when a source is asserted but not enabled. The bench creates exactly that condition under both settings of the bit. Any corruption of a stored register, including data leaking into an unpopulated bit, appears on the read return one cycle after the read request.

// File: rtl/intc_steer_pkg.sv
package intc_steer_pkg;
  localparam int unsigned SRC_N  = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 5;

  // populated source positions: 8..14 and 17..31
  localparam logic [SRC_N-1:0] POP_SET = 32'hFFFE_7F00;

  localparam logic [ADDR_W-1:0] OFS_PEND  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_ENA   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_STEER = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h14;

  typedef enum logic [2:0] {
    SEL_PEND, SEL_ENA, SEL_STEER, SEL_CTRL, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_PEND:  return SEL_PEND;
      OFS_ENA:   return SEL_ENA;
      OFS_STEER: return SEL_STEER;
      OFS_CTRL:  return SEL_CTRL;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/intc_steer_regs.sv
module intc_steer_regs
  import intc_steer_pkg::*;
#(
  parameter int unsigned     N_SRC  = SRC_N,
  parameter int unsigned     DW     = DATA_W,
  parameter int unsigned     AW     = ADDR_W,
  parameter logic [N_SRC-1:0] POP   = POP_SET
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [N_SRC-1:0] pend_view,
  output logic [N_SRC-1:0] ena_q,
  output logic [N_SRC-1:0] steer_q,
  output logic             qual_q,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data
);
  localparam int unsigned PAD = DW - N_SRC;

  reg_sel_e         sel;
  logic             wr_go, rd_go;
  logic [DW-1:0]    rd_mux;
  logic [N_SRC-1:0] wsrc;

  assign sel   = decode_ofs(req_addr);
  assign wr_go = req_valid & req_write;
  assign rd_go = req_valid & ~req_write;
  assign wsrc  = req_wdata[N_SRC-1:0] & POP;

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q   <= '0;
      steer_q <= '0;
      qual_q  <= 1'b0;
    end else if (wr_go) begin
      case (sel)
        SEL_ENA:   ena_q   <= wsrc;
        SEL_STEER: steer_q <= wsrc;
        SEL_CTRL:  qual_q  <= req_wdata[0];
        default: ;
      endcase
    end
  end

  generate
    if (PAD > 0) begin : g_pad
      always_comb begin
        rd_mux = '0;
        case (sel)
          SEL_PEND:  rd_mux = {{PAD{1'b0}}, pend_view};
          SEL_ENA:   rd_mux = {{PAD{1'b0}}, ena_q};
          SEL_STEER: rd_mux = {{PAD{1'b0}}, steer_q};
          SEL_CTRL:  rd_mux = {{(DW-1){1'b0}}, qual_q};
          default:   rd_mux = '0;
        endcase
      end
    end else begin : g_nopad
      always_comb begin
        rd_mux = '0;
        case (sel)
          SEL_PEND:  rd_mux = pend_view;
          SEL_ENA:   rd_mux = ena_q;
          SEL_STEER: rd_mux = steer_q;
          SEL_CTRL:  rd_mux = {{(DW-1){1'b0}}, qual_q};
          default:   rd_mux = '0;
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_go;
      rd_data  <= rd_go ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/intc_steer_route.sv
module intc_steer_route #(
  parameter int unsigned      N_SRC = 32,
  parameter logic [N_SRC-1:0] POP   = 32'hFFFE_7F00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_lines,
  input  logic [N_SRC-1:0] ena_q,
  input  logic [N_SRC-1:0] steer_q,
  input  logic             qual_q,
  output logic [N_SRC-1:0] pend_view,
  output logic             irq_out,
  output logic             fiq_out,
  output logic             wake_out
);
  logic [N_SRC-1:0] live, to_irq, to_fiq;

  genvar i;
  generate
    for (i = 0; i < N_SRC; i++) begin : g_src
      if (POP[i]) begin : g_pop
        assign live[i]   = src_lines[i];
        assign to_irq[i] = src_lines[i] & ena_q[i] & ~steer_q[i];
        assign to_fiq[i] = src_lines[i] & ena_q[i] &  steer_q[i];
      end else begin : g_hole
        assign live[i]   = 1'b0;
        assign to_irq[i] = 1'b0;
        assign to_fiq[i] = 1'b0;
      end
    end
  endgenerate

  assign pend_view = live;
  // no clock in this path: an idle core with stopped clocks still wakes
  assign wake_out  = qual_q ? |(live & ena_q) : |live;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out <= 1'b0;
      fiq_out <= 1'b0;
    end else begin
      irq_out <= |to_irq;
      fiq_out <= |to_fiq;
    end
  end
endmodule

// File: rtl/intc_steer_top.sv
module intc_steer_top
  import intc_steer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_N-1:0]  src_lines,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_out,
  output logic              fiq_out,
  output logic              wake_out
);
  logic [SRC_N-1:0] ena_q, steer_q, pend_view;
  logic             qual_q;

  intc_steer_regs #(.N_SRC(SRC_N), .DW(DATA_W), .AW(ADDR_W), .POP(POP_SET)) u_regs (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .pend_view(pend_view),
    .ena_q(ena_q), .steer_q(steer_q), .qual_q(qual_q),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  intc_steer_route #(.N_SRC(SRC_N), .POP(POP_SET)) u_route (
    .clk(clk), .rst(rst),
    .src_lines(src_lines), .ena_q(ena_q), .steer_q(steer_q), .qual_q(qual_q),
    .pend_view(pend_view),
    .irq_out(irq_out), .fiq_out(fiq_out), .wake_out(wake_out)
  );
endmodule

// File: rtl/intc_steer_chk.sv
module intc_steer_chk
  import intc_steer_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_write,
  input logic [SRC_N-1:0] src_lines,
  input logic [SRC_N-1:0] ena_q,
  input logic             qual_q,
  input logic             rd_valid,
  input logic             irq_out,
  input logic             fiq_out,
  input logic             wake_out
);
  logic             any_live, any_live_ena;
  logic [SRC_N-1:0] live;

  assign live         = src_lines & POP_SET;
  assign any_live     = |live;
  assign any_live_ena = |(live & ena_q);

  AST_RD_ANSWERED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);                        // R11
  AST_RD_UNSOLICITED: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rd_valid);                      // R11
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|((src_lines & POP_SET) & ena_q)));           // R6
  AST_FIQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    fiq_out |-> $past(|((src_lines & POP_SET) & ena_q)));           // R7
  AST_WAKE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    wake_out |-> any_live);                                         // R10
  AST_WAKE_OPEN: assert property (@(posedge clk) disable iff (rst)
    (!qual_q && any_live) |-> wake_out);                            // R8
  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (rst)
    (qual_q && wake_out) |-> any_live_ena);                         // R9
endmodule

bind intc_steer_top intc_steer_chk u_chk (
  .clk(clk), .rst(rst),
  .req_valid(req_valid), .req_write(req_write),
  .src_lines(src_lines), .ena_q(ena_q), .qual_q(qual_q),
  .rd_valid(rd_valid), .irq_out(irq_out), .fiq_out(fiq_out), .wake_out(wake_out)
);

// File: tb/tb_intc_steer_top.sv
`timescale 1ns/1ps
module tb_intc_steer_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_lines = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid, irq_out, fiq_out, wake_out;
  logic [31:0] rd_data;

  int errors = 0;
  int checks = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t exp_q[$];

  always #2 clk = ~clk;

  intc_steer_top dut (
    .clk(clk), .rst(rst), .src_lines(src_lines),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .irq_out(irq_out), .fiq_out(fiq_out), .wake_out(wake_out)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk);
    src_lines = v;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic outs(input logic i, input logic f, input logic w, input string tag);
    check(irq_out == i, {tag, " irq"}, {31'b0, irq_out}, {31'b0, i});
    check(fiq_out == f, {tag, " fiq"}, {31'b0, fiq_out}, {31'b0, f});
    check(wake_out == w, {tag, " wake"}, {31'b0, wake_out}, {31'b0, w});
  endtask

  // monitor: pops expected read returns
  always @(posedge clk) begin
    #1;
    if (rd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R11 unexpected read return", rd_data, '0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        check(rd_data === it.exp, it.tag, rd_data, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    src_lines = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    outs(1'b0, 1'b0, 1'b1, "R1 R8 after reset");
    rd(5'h04, 32'h0, "R1 enable reset");
    rd(5'h08, 32'h0, "R1 steering reset");
    rd(5'h14, 32'h0, "R1 control reset");
    rd(5'h00, 32'hFFFE_7F00, "R2 pending view");
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, 32'hFFFE_7F00, "R3 enable reserved");
    wr(5'h08, 32'h0000_FFFF);
    rd(5'h08, 32'h0000_7F00, "R4 steering reserved");
    wr(5'h14, 32'hFFFF_FFFF);
    rd(5'h14, 32'h0000_0001, "R5 control bit");
    wr(5'h14, 32'h0);
    wr(5'h0C, 32'hDEAD_BEEF);
    rd(5'h0C, 32'h0, "R11 unmapped 0x0C");
    rd(5'h10, 32'h0, "R11 unmapped 0x10");
    rd(5'h04, 32'hFFFE_7F00, "R11 unmapped write no effect");

    set_src(32'h0000_0100);
    outs(1'b0, 1'b1, 1'b1, "R7 src8 fast");
    set_src(32'h0010_0000);
    outs(1'b1, 1'b0, 1'b1, "R6 src20 normal");
    set_src(32'h0010_0100);
    outs(1'b1, 1'b1, 1'b1, "R6 R7 both");
    set_src(32'h0000_0008);
    outs(1'b0, 1'b0, 1'b0, "R10 src3 hole");
    set_src(32'h0001_8000);
    outs(1'b0, 1'b0, 1'b0, "R10 src15/16 hole");
    rd(5'h00, 32'h0, "R2 hole pending");

    wr(5'h04, 32'h0);
    set_src(32'h0010_0000);
    outs(1'b0, 1'b0, 1'b1, "R8 masked still wakes");
    wr(5'h14, 32'h1);
    @(posedge clk); #1;
    outs(1'b0, 1'b0, 1'b0, "R9 masked no wake");
    wr(5'h04, 32'h0010_0000);
    @(posedge clk); #1;
    outs(1'b1, 1'b0, 1'b1, "R9 enabled wakes");
    set_src(32'h0000_0200);
    outs(1'b0, 1'b0, 1'b0, "R9 other disabled");

    repeat (4) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R11 read returns outstanding", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule